// File: doc/BRIEF.md
# Transceiver power-mode sequencer

This block is a synchronous controller that decides which power mode a single-wire bus transceiver with an on-chip regulator is in. It watches a chip-select/wake pin, a bus-activity indication, a regulator-stable flag and two comparator flags. From these it drives the transmitter enable, the regulator enable and a latched slope choice, and it reports a mode code.

Chip-select/wake acts on edges only. Both it and the bus-activity input pass through two-flop synchronizers first. After the regulator reports stable, a parameterized blanking window starts, and edges that arrive inside it are dropped. The mode out of reset depends on the pin level sampled in the power-on state. A regulator undervoltage shuts the regulator off. The block then waits for the battery comparator and starts over from the power-on state.

The transmit data input is gated so that the bus is driven dominant only while the transmitter is enabled.

Top module: `pwr_mode_fsm`

## Requirements
- R1: While reset is asserted, and in the power-on state, the mode code is 0, and the transmitter enable and the regulator enable are both 0.
- R2: When the power-on state ends, the synchronized chip-select/wake level picks the next mode. Low gives Ready (code 1) and high gives Ready1 (code 2). The slope-select pin is latched at the same moment.
- R3: Ready1 changes only on an accepted falling edge of chip-select/wake, and it goes to Ready. A rising edge has no effect in Ready1.
- R4: Ready goes to Operation (code 3) on an accepted rising edge. Falling edges and bus activity have no effect in Ready.
- R5: Operation goes to Power-down (code 4) on an accepted falling edge. Power-down is entered from no other mode.
- R6: After the regulator-stable flag rises, chip-select/wake edges are discarded for BLANK_CYC cycles, and a level held through the window causes no transition. The counter clears whenever the flag drops. In Power-down, rising edges are accepted without blanking.
- R7: In Power-down, a rising edge of chip-select/wake goes straight to Operation.
- R8: In Power-down, a rising edge of bus activity turns the regulator enable on while the mode stays 4. The block enters Ready once the regulator reports stable.
- R9: The transmitter enable is 1 only in Operation. The regulator enable is 1 in Ready, Ready1 and Operation, and in Power-down after a bus wake. The bus-drive output is 1 (dominant) only when the transmitter is enabled and the transmit data is 0.
- R10: An undervoltage flag raised while the regulator is enabled moves the block to Brownout (code 5) with the regulator off. The block stays there while the battery-above-turn-on flag is low.
- R11: In Brownout, a high battery-above-turn-on flag returns the block to the power-on state, which samples the pin level and the slope select again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_wake | input | 1 | Chip-select/wake pin, asynchronous |
| bus_act | input | 1 | Bus-activity indication, asynchronous |
| reg_stable | input | 1 | Regulator output stable |
| reg_uv | input | 1 | Regulator below shutdown threshold |
| bat_on | input | 1 | Battery above turn-on threshold |
| slope_sel | input | 1 | Slope-select pin |
| txd | input | 1 | Transmit data, 0 = dominant |
| tx_en | output | 1 | Transmitter enable |
| reg_en | output | 1 | Regulator enable |
| slope_lat | output | 1 | Latched slope selection |
| bus_dom | output | 1 | Drive bus dominant |
| mode | output | 3 | Mode code: 0 power-on, 1 Ready, 2 Ready1, 3 Operation, 4 Power-down, 5 Brownout |

## Verification
The bench moves the pin inside the blanking window and then holds the new level past the end of the window. A design that queued edges, or that reacted to levels, would leave Ready or Ready1 at that point. It also raises the pin in Ready1 and lowers it in Ready, where a design that ignored the mode-specific edge direction would move. Power-down is left both by a bus wake and by a pin wake with the regulator not stable, which catches blanking wrongly applied to the wake path. A brownout followed by a restart with new pin and slope levels exposes a block that skipped re-sampling or left the regulator on.

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm #(
  parameter int BLANK_CYC = 30000,
  parameter int POR_CYC   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_wake,
  input  logic       bus_act,
  input  logic       reg_stable,
  input  logic       reg_uv,
  input  logic       bat_on,
  input  logic       slope_sel,
  input  logic       txd,
  output logic       tx_en,
  output logic       reg_en,
  output logic       slope_lat,
  output logic       bus_dom,
  output logic [2:0] mode
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam int PW = $clog2(POR_CYC + 1);
  localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);
  localparam logic [PW-1:0] POR_END   = PW'(POR_CYC - 1);
  localparam logic [2:0] M_POR = 3'd0, M_RDY = 3'd1, M_RDY1 = 3'd2,
                         M_OP  = 3'd3, M_PDN = 3'd4, M_BRN  = 3'd5;

  logic [2:0]    st;
  logic [1:0]    cs_sy, bus_sy;
  logic          cs_d, bus_d, wake_pend;
  logic [CW-1:0] blank;
  logic [PW-1:0] por_cnt;

  wire armed    = (blank == BLANK_END);
  wire cs_rise  = cs_sy[1] & ~cs_d;
  wire cs_fall  = ~cs_sy[1] & cs_d;
  wire bus_ev   = bus_sy[1] & ~bus_d;
  wire acc_rise = cs_rise & (armed | (st == M_PDN));
  wire acc_fall = cs_fall & armed;

  assign mode    = st;
  assign tx_en   = (st == M_OP);
  assign reg_en  = (st == M_RDY) | (st == M_RDY1) | (st == M_OP) | ((st == M_PDN) & wake_pend);
  assign bus_dom = tx_en & ~txd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= '0;
      bus_sy <= '0;
      cs_d   <= 1'b0;
      bus_d  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[0], cs_wake};
      bus_sy <= {bus_sy[0], bus_act};
      cs_d   <= cs_sy[1];
      bus_d  <= bus_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           blank <= '0;
    else if (!reg_stable) blank <= '0;
    else if (!armed)      blank <= blank + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= M_POR;
      por_cnt   <= '0;
      slope_lat <= 1'b0;
      wake_pend <= 1'b0;
    end else if (reg_en && reg_uv) begin
      st        <= M_BRN;
      wake_pend <= 1'b0;
    end else begin
      case (st)
        M_POR:
          if (por_cnt == POR_END) begin
            st        <= cs_sy[1] ? M_RDY1 : M_RDY;
            slope_lat <= slope_sel;
          end else begin
            por_cnt <= por_cnt + 1'b1;
          end
        M_RDY1:  if (acc_fall) st <= M_RDY;
        M_RDY:   if (acc_rise) st <= M_OP;
        M_OP:    if (acc_fall) st <= M_PDN;
        M_PDN:
          if (acc_rise) begin
            st        <= M_OP;
            wake_pend <= 1'b0;
          end else if (wake_pend && reg_stable) begin
            st        <= M_RDY;
            wake_pend <= 1'b0;
          end else if (bus_ev) begin
            wake_pend <= 1'b1;
          end
        M_BRN:
          if (bat_on) begin
            st      <= M_POR;
            por_cnt <= '0;
          end
        default: st <= M_POR;
      endcase
    end
  end
endmodule

module pwr_mode_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bat_on,
  input logic       tx_en,
  input logic       reg_en,
  input logic       bus_dom,
  input logic [2:0] mode
);
  assert_bus_recessive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dom |-> tx_en);

  assert_tx_needs_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> reg_en);

  assert_pdown_from_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && $past(mode) != 3'd4) |-> $past(mode) == 3'd3);

  assert_brownout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && !bat_on) |=> mode == 3'd5);

  assert_brownout_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd5 && mode != 3'd5) |-> mode == 3'd0);

  assert_brownout_regoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 || mode == 3'd0) |-> !reg_en);
endmodule

bind pwr_mode_fsm pwr_mode_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bat_on(bat_on), .tx_en(tx_en),
  .reg_en(reg_en), .bus_dom(bus_dom), .mode(mode)
);

// File: tb/tb_pwr_mode_fsm.sv
module tb_pwr_mode_fsm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_wake = 1'b1, bus_act = 1'b0, reg_stable = 1'b0, reg_uv = 1'b0;
  logic bat_on = 1'b0, slope_sel = 1'b1, txd = 1'b1;
  logic tx_en, reg_en, slope_lat, bus_dom;
  logic [2:0] mode;
  int errors = 0, checks = 0;
  bit done = 0;

  pwr_mode_fsm #(.BLANK_CYC(20), .POR_CYC(3)) dut (
    .clk(clk), .rst_n(rst_n), .cs_wake(cs_wake), .bus_act(bus_act),
    .reg_stable(reg_stable), .reg_uv(reg_uv), .bat_on(bat_on),
    .slope_sel(slope_sel), .txd(txd), .tx_en(tx_en), .reg_en(reg_en),
    .slope_lat(slope_lat), .bus_dom(bus_dom), .mode(mode)
  );

  always #10 clk = ~clk;

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset_por;
    wn(3);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset reg_en", reg_en, 0);
    chk("R1 reset tx_en", tx_en, 0);
    rst_n = 1'b1;
    wn(8);
    chk("R2 high pin gives Ready1", mode, 2);
    chk("R2 slope latched 1", slope_lat, 1);
    chk("R9 reg on in Ready1", reg_en, 1);
    chk("R9 tx off in Ready1", tx_en, 0);
  endtask

  task automatic t_ready1;
    reg_stable = 1'b1;
    wn(3);
    cs_wake = 1'b0;
    wn(6);
    chk("R6 fall in blanking dropped", mode, 2);
    wn(30);
    chk("R6 low level after blanking no effect", mode, 2);
    cs_wake = 1'b1;
    wn(6);
    chk("R3 rise ignored in Ready1", mode, 2);
    cs_wake = 1'b0;
    wn(6);
    chk("R3 fall moves Ready1 to Ready", mode, 1);
  endtask

  task automatic t_ready_op;
    txd = 1'b0;
    bus_act = 1'b1; wn(3); bus_act = 1'b0;
    wn(5);
    chk("R4 bus activity ignored in Ready", mode, 1);
    chk("R9 recessive in Ready", bus_dom, 0);
    cs_wake = 1'b1;
    wn(6);
    chk("R4 rise moves Ready to Operation", mode, 3);
    chk("R9 tx on in Operation", tx_en, 1);
    chk("R9 dominant drive in Operation", bus_dom, 1);
    txd = 1'b1;
    wn(1);
    chk("R9 txd high recessive", bus_dom, 0);
    cs_wake = 1'b0;
    wn(6);
    chk("R5 fall moves Operation to Power-down", mode, 4);
    chk("R9 reg off in Power-down", reg_en, 0);
    chk("R9 tx off in Power-down", tx_en, 0);
    reg_stable = 1'b0;
  endtask

  task automatic t_pdown_bus;
    wn(4);
    bus_act = 1'b1; wn(3); bus_act = 1'b0;
    wn(5);
    chk("R8 bus wake keeps Power-down", mode, 4);
    chk("R8 bus wake turns reg on", reg_en, 1);
    reg_stable = 1'b1;
    wn(3);
    chk("R8 stable reg enters Ready", mode, 1);
    cs_wake = 1'b1;
    wn(6);
    chk("R6 rise in blanking dropped", mode, 1);
    wn(30);
    chk("R6 high level after blanking no effect", mode, 1);
    cs_wake = 1'b0;
    wn(6);
    chk("R4 fall ignored in Ready", mode, 1);
    cs_wake = 1'b1;
    wn(6);
    chk("R4 rise after blanking to Operation", mode, 3);
    cs_wake = 1'b0;
    wn(6);
    chk("R5 second entry to Power-down", mode, 4);
    reg_stable = 1'b0;
  endtask

  task automatic t_pdown_cs;
    wn(4);
    cs_wake = 1'b1;
    wn(6);
    chk("R7 pin rise wakes to Operation", mode, 3);
    chk("R7 tx on after pin wake", tx_en, 1);
    reg_stable = 1'b1;
    wn(30);
  endtask

  task automatic t_brownout;
    slope_sel = 1'b0;
    cs_wake = 1'b0;
    reg_uv = 1'b1;
    wn(2);
    chk("R10 undervoltage enters Brownout", mode, 5);
    chk("R10 reg off in Brownout", reg_en, 0);
    chk("R10 tx off in Brownout", tx_en, 0);
    reg_stable = 1'b0;
    reg_uv = 1'b0;
    wn(20);
    chk("R10 held while battery low", mode, 5);
    bat_on = 1'b1;
    wn(2);
    chk("R11 restart through power-on state", mode, 0);
    wn(8);
    chk("R11 low pin resampled gives Ready", mode, 1);
    chk("R11 slope resampled 0", slope_lat, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_por();
    t_ready1();
    t_ready_op();
    t_pdown_bus();
    t_pdown_cs();
    t_brownout();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule